// File: doc/BRIEF.md
# Stack Pointer Update Unit

This block holds the stack pointer of a small 8-bit controller and moves it for every stack operation. Single-byte pushes and pops move the pointer by one; saving or restoring a return address (call, interrupt entry, return) takes one byte per cycle over two consecutive cycles, so the pointer moves by two in total. For each byte moved the unit presents the data memory address to use and a write or read strobe. A push writes at the current pointer and then steps down. A pop steps up first and reads at the new value.

Software reaches the pointer through an I/O-mapped register that can be read and written. A write through that port overrides any stack activity in the same cycle and cancels an unfinished address transfer. A sticky range flag records a push into the reserved low area or any wrap of the pointer past either end. Reloading the pointer through the I/O port clears the flag.

Top module: `sp_unit`

## Requirements
- R1: While reset is low at a clock edge, the pointer becomes 0x00, the range flag clears, the unit is not busy, and neither memory strobe is raised.
- R2: A byte push raises the write strobe with the memory address equal to the current pointer, and the pointer is one lower after the edge.
- R3: A byte pop raises the read strobe with the memory address equal to the pointer plus one, and the pointer is one higher after the edge.
- R4: An address push writes the low byte at the pointer in its first cycle and the high byte at pointer minus one in the next cycle. The pointer drops by two in total and busy is high in the second cycle, when all stack strobes are ignored.
- R5: An address pop reads at pointer plus one and then at pointer plus two in two consecutive cycles. The pointer rises by two in total and busy is high in the second cycle.
- R6: An I/O write to address 0x3D loads the pointer at the next edge. It suppresses any stack strobe in the same cycle, cancels a pending second byte, and clears the range flag.
- R7: With the read enable high and the I/O address 0x3D, the read data equals the pointer; otherwise it is 0x00. A write to any other I/O address leaves the pointer unchanged.
- R8: A push (byte or address phase) made while the pointer is at or below 0x60 sets the range flag at the next edge, and the flag stays set.
- R9: A pop at 0xFF wraps the pointer to 0x00, and a push at 0x00 wraps it to 0xFF. Either wrap sets the sticky range flag.
- R10: When several stack strobes arrive in the same idle cycle, exactly one is served, with priority byte push, byte pop, address push, address pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_byte_i | input | 1 | Push one data byte |
| pop_byte_i | input | 1 | Pop one data byte |
| push_addr_i | input | 1 | Start saving a return address (call or interrupt) |
| pop_addr_i | input | 1 | Start restoring a return address (return) |
| io_addr_i | input | 6 | I/O register address |
| io_wr_i | input | 1 | I/O write enable |
| io_rd_i | input | 1 | I/O read enable |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data, pointer when selected, else zero |
| sp_o | output | 8 | Current stack pointer |
| mem_addr_o | output | 8 | Data memory address for this cycle's stack byte |
| mem_we_o | output | 1 | Stack byte write this cycle |
| mem_re_o | output | 1 | Stack byte read this cycle |
| busy_o | output | 1 | Second byte of an address transfer in progress |
| range_err_o | output | 1 | Sticky stack range flag |

## Verification
The bench builds the unit with its default parameters: an 8-bit pointer, I/O select 0x3D, a floor of 0x60 and two-byte return addresses. With an 8-bit pointer both wrap edges lie one step from values loaded through the I/O port. The floor can be crossed with two pushes, so the range flag can be driven from every source. The two-byte address width lets one cancel of an unfinished transfer be checked in a single cycle.

// File: rtl/sp_pkg.sv
// Shared types for the stack pointer unit.
// Assumes: nothing beyond the standard types.
package sp_pkg;

    // Direction the pointer moves this cycle
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_DOWN = 2'd1,
        STEP_UP   = 2'd2
    } sp_step_e;

    // Stack requests sampled in one cycle
    typedef struct packed {
        logic push_b;
        logic pop_b;
        logic push_a;
        logic pop_a;
    } sp_req_t;

endpackage

// File: rtl/sp_seq.sv
// Stack operation sequencer: turns strobes into one pointer step per cycle.
// A multi-byte address transfer keeps stepping in the same direction for
// ADDR_BYTES cycles. An I/O takeover cancels everything.
// Assumes: ADDR_BYTES >= 2; strobes arriving while busy are dropped.
module sp_seq
    import sp_pkg::*;
#(
    parameter int ADDR_BYTES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  sp_req_t  req,
    input  logic     io_take,
    output sp_step_e step,
    output logic     busy
);
    localparam int CW = (ADDR_BYTES > 2) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [CW-1:0] FOLLOW = CW'(ADDR_BYTES - 1);

    logic [CW-1:0] left_q, left_d;
    logic          up_q, up_d;

    assign busy = (left_q != '0);

    // Pick this cycle's step and the remaining byte count
    always_comb begin
        step   = STEP_NONE;
        left_d = left_q;
        up_d   = up_q;
        if (io_take) begin
            left_d = '0;
        end else if (busy) begin
            step   = up_q ? STEP_UP : STEP_DOWN;
            left_d = left_q - 1'b1;
        end else if (req.push_b) begin
            step = STEP_DOWN;
        end else if (req.pop_b) begin
            step = STEP_UP;
        end else if (req.push_a) begin
            step   = STEP_DOWN;
            left_d = FOLLOW;
            up_d   = 1'b0;
        end else if (req.pop_a) begin
            step   = STEP_UP;
            left_d = FOLLOW;
            up_d   = 1'b1;
        end
    end

    // Hold the remaining byte count and direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            up_q   <= 1'b0;
        end else begin
            left_q <= left_d;
            up_q   <= up_d;
        end
    end

endmodule

// File: rtl/sp_arith.sv
// Pointer arithmetic: next value, byte address and range events for a step.
// The write address is the pointer itself (write, then decrement). The read
// address is the pointer plus one (increment, then read).
// Assumes: step is one of the three encoded values.
module sp_arith
    import sp_pkg::*;
#(
    parameter int SP_W  = 8,
    parameter int FLOOR = 'h60
) (
    input  logic [SP_W-1:0] sp,
    input  sp_step_e        step,
    output logic [SP_W-1:0] sp_next,
    output logic [SP_W-1:0] mem_addr,
    output logic            wrap,
    output logic            low
);
    localparam logic [SP_W-1:0] FLOOR_V = SP_W'(FLOOR);
    localparam logic [SP_W-1:0] TOP_V   = {SP_W{1'b1}};

    logic [SP_W-1:0] sp_up, sp_dn;

    assign sp_up = sp + 1'b1;
    assign sp_dn = sp - 1'b1;

    // Select next pointer, address and events from the step direction
    always_comb begin
        sp_next  = sp;
        mem_addr = sp;
        wrap     = 1'b0;
        low      = 1'b0;
        case (step)
            STEP_DOWN: begin
                sp_next  = sp_dn;
                mem_addr = sp;
                wrap     = (sp == '0);
                low      = (sp <= FLOOR_V);
            end
            STEP_UP: begin
                sp_next  = sp_up;
                mem_addr = sp_up;
                wrap     = (sp == TOP_V);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sp_flag.sv
// Sticky range flag: set by a push at or below the floor or by any wrap,
// cleared when software reloads the pointer.
// Assumes: low is only meaningful for downward steps.
module sp_flag
    import sp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     io_take,
    input  sp_step_e step,
    input  logic     wrap,
    input  logic     low,
    output logic     flag
);
    logic hit;

    assign hit = ((step == STEP_DOWN) && (low || wrap)) ||
                 ((step == STEP_UP) && wrap);

    // Set on a range event, clear on an I/O reload
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (io_take) flag <= 1'b0;
        else if (hit)     flag <= 1'b1;
    end

endmodule

// File: rtl/sp_unit.sv
// Stack pointer update unit: holds the pointer, steps it per stack request,
// drives the stack byte address and strobes, and exposes the pointer as an
// I/O register.
// Assumes: at most one stack strobe per cycle by convention (priority
// resolves violations); the data memory samples mem_addr_o with the strobes.
module sp_unit
    import sp_pkg::*;
#(
    parameter int SP_W       = 8,
    parameter int IO_AW      = 6,
    parameter int IO_SP_ADDR = 'h3D,
    parameter int FLOOR      = 'h60,
    parameter int ADDR_BYTES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_byte_i,
    input  logic             pop_byte_i,
    input  logic             push_addr_i,
    input  logic             pop_addr_i,
    input  logic [IO_AW-1:0] io_addr_i,
    input  logic             io_wr_i,
    input  logic             io_rd_i,
    input  logic [SP_W-1:0]  io_wdata_i,
    output logic [SP_W-1:0]  io_rdata_o,
    output logic [SP_W-1:0]  sp_o,
    output logic [SP_W-1:0]  mem_addr_o,
    output logic             mem_we_o,
    output logic             mem_re_o,
    output logic             busy_o,
    output logic             range_err_o
);
    localparam logic [IO_AW-1:0] SP_SEL = IO_AW'(IO_SP_ADDR);

    sp_req_t         req;
    sp_step_e        step;
    logic            io_take;
    logic [SP_W-1:0] sp_q, sp_next;
    logic            wrap, low;

    assign req     = '{push_b: push_byte_i, pop_b: pop_byte_i,
                       push_a: push_addr_i, pop_a: pop_addr_i};
    assign io_take = io_wr_i && (io_addr_i == SP_SEL);

    sp_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .io_take (io_take),
        .step    (step),
        .busy    (busy_o)
    );

    sp_arith #(.SP_W(SP_W), .FLOOR(FLOOR)) u_arith (
        .sp       (sp_q),
        .step     (step),
        .sp_next  (sp_next),
        .mem_addr (mem_addr_o),
        .wrap     (wrap),
        .low      (low)
    );

    sp_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_take (io_take),
        .step    (step),
        .wrap    (wrap),
        .low     (low),
        .flag    (range_err_o)
    );

    // Pointer register: I/O load first, then stack step
    always_ff @(posedge clk) begin
        if (!rst_n)                  sp_q <= '0;
        else if (io_take)            sp_q <= io_wdata_i;
        else if (step != STEP_NONE)  sp_q <= sp_next;
    end

    assign sp_o       = sp_q;
    assign mem_we_o   = (step == STEP_DOWN);
    assign mem_re_o   = (step == STEP_UP);
    assign io_rdata_o = (io_rd_i && (io_addr_i == SP_SEL)) ? sp_q : '0;

endmodule

// File: rtl/sp_unit_chk.sv
// Property checker for sp_unit, attached by bind. Observes ports only.
module sp_unit_chk #(
    parameter int SP_W       = 8,
    parameter int IO_AW      = 6,
    parameter int IO_SP_ADDR = 'h3D,
    parameter int FLOOR      = 'h60
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_byte_i,
    input logic             pop_byte_i,
    input logic             push_addr_i,
    input logic             pop_addr_i,
    input logic [IO_AW-1:0] io_addr_i,
    input logic             io_wr_i,
    input logic             io_rd_i,
    input logic [SP_W-1:0]  io_wdata_i,
    input logic [SP_W-1:0]  io_rdata_o,
    input logic [SP_W-1:0]  sp_o,
    input logic [SP_W-1:0]  mem_addr_o,
    input logic             mem_we_o,
    input logic             mem_re_o,
    input logic             busy_o,
    input logic             range_err_o
);
    localparam logic [IO_AW-1:0] SEL     = IO_AW'(IO_SP_ADDR);
    localparam logic [SP_W-1:0]  FLOOR_V = SP_W'(FLOOR);

    logic io_hit, idle_push_a, idle_pop_a;
    assign io_hit      = io_wr_i && (io_addr_i == SEL);
    assign idle_push_a = push_addr_i && !push_byte_i && !pop_byte_i && !busy_o && !io_hit;
    assign idle_pop_a  = pop_addr_i && !push_addr_i && !push_byte_i && !pop_byte_i && !busy_o && !io_hit;

    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (sp_o == '0 && !range_err_o && !busy_o)); // R1
    AST_PUSH_STEP:   assert property (@(posedge clk) disable iff (!rst_n) (push_byte_i && !busy_o && !io_hit) |=> sp_o == SP_W'($past(sp_o) - 1'b1)); // R2
    AST_WR_AT_SP:    assert property (@(posedge clk) disable iff (!rst_n) mem_we_o |-> mem_addr_o == sp_o); // R2
    AST_POP_STEP:    assert property (@(posedge clk) disable iff (!rst_n) (pop_byte_i && !push_byte_i && !busy_o && !io_hit) |=> sp_o == SP_W'($past(sp_o) + 1'b1)); // R3
    AST_RD_ABOVE:    assert property (@(posedge clk) disable iff (!rst_n) mem_re_o |-> mem_addr_o == SP_W'(sp_o + 1'b1)); // R3
    AST_ADDR_PUSH:   assert property (@(posedge clk) disable iff (!rst_n) idle_push_a |=> (busy_o && sp_o == SP_W'($past(sp_o) - 1'b1))); // R4
    AST_ADDR_POP:    assert property (@(posedge clk) disable iff (!rst_n) idle_pop_a |=> (busy_o && sp_o == SP_W'($past(sp_o) + 1'b1))); // R5
    AST_IO_LOAD:     assert property (@(posedge clk) disable iff (!rst_n) io_hit |=> (sp_o == $past(io_wdata_i) && !range_err_o && !busy_o)); // R6
    AST_IO_READ:     assert property (@(posedge clk) disable iff (!rst_n) (io_rd_i && io_addr_i == SEL) |-> io_rdata_o == sp_o); // R7
    AST_FLOOR_FLAG:  assert property (@(posedge clk) disable iff (!rst_n) (mem_we_o && sp_o <= FLOOR_V && !io_hit) |=> range_err_o); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (range_err_o && !io_hit) |=> range_err_o); // R9
    AST_ONE_STROBE:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0({mem_we_o, mem_re_o})); // R10

endmodule

bind sp_unit sp_unit_chk #(
    .SP_W(SP_W), .IO_AW(IO_AW), .IO_SP_ADDR(IO_SP_ADDR), .FLOOR(FLOOR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .push_byte_i(push_byte_i), .pop_byte_i(pop_byte_i),
    .push_addr_i(push_addr_i), .pop_addr_i(pop_addr_i), .io_addr_i(io_addr_i),
    .io_wr_i(io_wr_i), .io_rd_i(io_rd_i), .io_wdata_i(io_wdata_i),
    .io_rdata_o(io_rdata_o), .sp_o(sp_o), .mem_addr_o(mem_addr_o),
    .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .busy_o(busy_o),
    .range_err_o(range_err_o)
);

// File: tb/test_sp_unit.sv
`timescale 1ns/1ps
module test_sp_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_byte_i = 1'b0, pop_byte_i = 1'b0;
    logic       push_addr_i = 1'b0, pop_addr_i = 1'b0;
    logic [5:0] io_addr_i = '0;
    logic       io_wr_i = 1'b0, io_rd_i = 1'b0;
    logic [7:0] io_wdata_i = '0;
    logic [7:0] io_rdata_o, sp_o, mem_addr_o;
    logic       mem_we_o, mem_re_o, busy_o, range_err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sp_unit i_sp_unit (
        .clk(clk), .rst_n(rst_n), .push_byte_i(push_byte_i), .pop_byte_i(pop_byte_i),
        .push_addr_i(push_addr_i), .pop_addr_i(pop_addr_i), .io_addr_i(io_addr_i),
        .io_wr_i(io_wr_i), .io_rd_i(io_rd_i), .io_wdata_i(io_wdata_i),
        .io_rdata_o(io_rdata_o), .sp_o(sp_o), .mem_addr_o(mem_addr_o),
        .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .busy_o(busy_o),
        .range_err_o(range_err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance one edge and settle past it
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_in();
        push_byte_i = 0; pop_byte_i = 0; push_addr_i = 0; pop_addr_i = 0;
        io_wr_i = 0; io_rd_i = 0;
    endtask

    task automatic load_sp(input logic [7:0] v);
        io_addr_i = 6'h3D; io_wdata_i = v; io_wr_i = 1;
        cyc();
        io_wr_i = 0;
    endtask

    task automatic t_reset();
        chk("R1 sp", sp_o, 8'h00);
        chk("R1 flag", range_err_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 strobes", {mem_we_o, mem_re_o}, 2'b00);
    endtask

    task automatic t_io();
        load_sp(8'h80);
        chk("R6 load", sp_o, 8'h80);
        io_rd_i = 1; io_addr_i = 6'h3D; #1;
        chk("R7 read sel", io_rdata_o, 8'h80);
        io_addr_i = 6'h3E; #1;
        chk("R7 read other", io_rdata_o, 8'h00);
        io_rd_i = 0;
        io_addr_i = 6'h3E; io_wdata_i = 8'h11; io_wr_i = 1;
        cyc(); io_wr_i = 0;
        chk("R7 write other ignored", sp_o, 8'h80);
    endtask

    task automatic t_byte();
        load_sp(8'h80);
        push_byte_i = 1; #1;
        chk("R2 we", mem_we_o, 1);
        chk("R2 addr", mem_addr_o, 8'h80);
        cyc(); push_byte_i = 0;
        chk("R2 sp", sp_o, 8'h7F);
        pop_byte_i = 1; #1;
        chk("R3 re", mem_re_o, 1);
        chk("R3 addr", mem_addr_o, 8'h80);
        cyc(); pop_byte_i = 0;
        chk("R3 sp", sp_o, 8'h80);
        chk("R8 no flag above floor", range_err_o, 0);
    endtask

    task automatic t_addr();
        load_sp(8'h90);
        push_addr_i = 1; #1;
        chk("R4 first we", mem_we_o, 1);
        chk("R4 first addr", mem_addr_o, 8'h90);
        cyc(); push_addr_i = 0;
        pop_byte_i = 1; #1;   // must be ignored while busy
        chk("R4 busy", busy_o, 1);
        chk("R4 second we", mem_we_o, 1);
        chk("R4 second addr", mem_addr_o, 8'h8F);
        cyc(); pop_byte_i = 0;
        chk("R4 sp", sp_o, 8'h8E);
        chk("R4 idle", busy_o, 0);
        pop_addr_i = 1; #1;
        chk("R5 first re", mem_re_o, 1);
        chk("R5 first addr", mem_addr_o, 8'h8F);
        cyc(); pop_addr_i = 0; #1;
        chk("R5 busy", busy_o, 1);
        chk("R5 second addr", mem_addr_o, 8'h90);
        cyc();
        chk("R5 sp", sp_o, 8'h90);
    endtask

    task automatic t_io_wins();
        load_sp(8'h90);
        push_byte_i = 1; io_addr_i = 6'h3D; io_wdata_i = 8'h40; io_wr_i = 1; #1;
        chk("R6 strobe suppressed", mem_we_o, 0);
        cyc(); clear_in();
        chk("R6 io over push", sp_o, 8'h40);
        load_sp(8'h90);
        push_addr_i = 1;
        cyc(); push_addr_i = 0;
        io_wdata_i = 8'h70; io_wr_i = 1;
        cyc(); io_wr_i = 0;
        chk("R6 cancel sp", sp_o, 8'h70);
        chk("R6 cancel busy", busy_o, 0);
    endtask

    task automatic t_floor();
        load_sp(8'h61);
        push_byte_i = 1;
        cyc();
        chk("R8 above floor", range_err_o, 0);
        chk("R8 sp", sp_o, 8'h60);
        cyc(); push_byte_i = 0;
        chk("R8 at floor", range_err_o, 1);
        cyc();
        chk("R8 sticky", range_err_o, 1);
        load_sp(8'h61);
        chk("R6 clear flag", range_err_o, 0);
    endtask

    task automatic t_wrap();
        load_sp(8'hFF);
        pop_byte_i = 1;
        cyc(); pop_byte_i = 0;
        chk("R9 pop wrap sp", sp_o, 8'h00);
        chk("R9 pop wrap flag", range_err_o, 1);
        load_sp(8'h00);
        push_byte_i = 1;
        cyc(); push_byte_i = 0;
        chk("R9 push wrap sp", sp_o, 8'hFF);
        chk("R9 push wrap flag", range_err_o, 1);
    endtask

    task automatic t_priority();
        load_sp(8'h80);
        push_byte_i = 1; pop_byte_i = 1;
        cyc(); clear_in();
        chk("R10 push over pop", sp_o, 8'h7F);
        pop_byte_i = 1; push_addr_i = 1;
        cyc(); clear_in();
        chk("R10 pop over addr sp", sp_o, 8'h80);
        chk("R10 pop over addr busy", busy_o, 0);
        push_addr_i = 1; pop_addr_i = 1;
        cyc(); clear_in();
        chk("R10 addr push first", sp_o, 8'h7F);
        cyc();
        chk("R10 addr push done", sp_o, 8'h7E);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1;
        t_io();
        t_byte();
        t_addr();
        t_io_wins();
        t_floor();
        t_wrap();
        t_priority();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule